// File: doc/BRIEF.md
# Page Translation Lookup with Access Protection

This block turns a 32-bit virtual address into a physical address using 8 KB pages and a set-associative translation cache. The cache has 16 sets of 4 ways each. It is kept in two banks. The instruction bank serves fetches, and the data bank serves loads and stores. For each request, the block reads all ways of the set chosen by the low bits of the virtual page. It then compares each way's page tag, and also compares either the way's process tag or its global flag.

On a match, the block runs four permission checks on the matching entry. Each check has its own enable bit in a configuration word. Only the highest-priority failing check is reported. The result is registered and appears one cycle after the request: the physical address, one of three outcomes (hit, miss or protection fault), and a small vector code that tells the fault handler which case occurred.

A simple synchronous write port loads either word of any entry, in either bank. Choosing which way to refill after a miss is left to the surrounding logic.

Top module: `tlb_xlate`

## Requirements
- R1: The virtual page number is req_vaddr[31:13] and the set index is req_vaddr[16:13]. On a match, rsp_paddr is {matching entry's tag-low[31:13], req_vaddr[12:0]}, whether or not a fault is raised.
- R2: A way matches when tag-high[31:13] equals the virtual page number and either tag-low[4] (global) is set or tag-high[7:0] equals req_pid.
- R3: When no way of the selected set matches, the response has rsp_miss set, rsp_vec 0 and rsp_paddr 0.
- R4: req_kind 2 (execute) looks up the instruction bank, written with wr_bank 0. req_kind 0 (read) and 1 (write) look up the data bank, written with wr_bank 1.
- R5: With cfg[18] set, a matching entry with tag-low[2] (kernel only) set, accessed with req_user high, faults with rsp_vec 2.
- R6: With cfg[19] set, a write to a matching entry whose tag-low[1] (writable) is clear faults with rsp_vec 3.
- R7: With cfg[17] set, an execute access to a matching entry whose tag-low[0] (executable) is clear faults with rsp_vec 4.
- R8: With cfg[16] set, a matching entry whose tag-low[3] (valid) is clear faults with rsp_vec 1.
- R9: When several checks fail, only one is reported, chosen in the order kernel, write, execute, valid.
- R10: A check whose enable bit in cfg is clear has no effect on the outcome.
- R11: When more than one way matches, the lowest-numbered way supplies the translation and the permission bits.
- R12: Each request with req_valid high yields, on the next cycle, rsp_valid with exactly one of rsp_hit, rsp_miss and rsp_fault. A cycle without a request yields rsp_valid low and all three outcome flags low.
- R13: During reset, all outputs are low and every entry word in both banks is zero. A zeroed entry therefore matches page 0 for process 0.
- R14: A write takes effect at the clock edge. A lookup in the same cycle as a write sees the entry's earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute |
| req_user | input | 1 | Access comes from user mode |
| req_pid | input | 8 | Current process tag |
| cfg | input | 32 | Check enables: [16] valid, [17] execute, [18] kernel, [19] write |
| wr_en | input | 1 | Entry write strobe |
| wr_bank | input | 1 | 0 instruction bank, 1 data bank |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 4 | Set to write |
| wr_hi | input | 32 | Tag-high word: page [31:13], process tag [7:0] |
| wr_lo | input | 32 | Tag-low word: frame [31:13], global [4], valid [3], kernel [2], writable [1], executable [0] |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No way matched |
| rsp_fault | output | 1 | Matched entry failed a check |
| rsp_vec | output | 3 | 0 miss, 1 invalid, 2 kernel, 3 write, 4 execute |
| rsp_paddr | output | 32 | Physical address |

## Verification
On every cycle, the assertions check the following. Each response follows its request by exactly one cycle and carries a single outcome. A miss always reports code 0 and address 0. A translated address keeps the request's page offset. A write-protection code can only follow a write request, and an invalid-entry code can only follow a request made with the valid check enabled. Only the bench scenarios can show the rest: which entry wins a match, which of several failing checks is reported, that each disabled check really has no effect, and that each access kind is routed to its own bank.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W     = 32;
    localparam int PG_BITS  = 13;
    localparam int VPN_W    = VA_W - PG_BITS;
    localparam int PID_W    = 8;
    localparam int VEC_W    = 3;
    localparam int NUM_BANK = 2;

    // tag-low bit positions
    localparam int LO_GLB = 4;
    localparam int LO_VLD = 3;
    localparam int LO_KRN = 2;
    localparam int LO_WR  = 1;
    localparam int LO_EX  = 0;

    // configuration enable positions
    localparam int CFG_VLD = 16;
    localparam int CFG_EX  = 17;
    localparam int CFG_KRN = 18;
    localparam int CFG_WR  = 19;

    // access kinds
    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    // bank numbers
    localparam int BANK_INSN = 0;
    localparam int BANK_DATA = 1;

    // vector codes
    localparam logic [VEC_W-1:0] VEC_MISS  = 3'd0;
    localparam logic [VEC_W-1:0] VEC_INVAL = 3'd1;
    localparam logic [VEC_W-1:0] VEC_KERN  = 3'd2;
    localparam logic [VEC_W-1:0] VEC_WRITE = 3'd3;
    localparam logic [VEC_W-1:0] VEC_EXEC  = 3'd4;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             miss;
        logic             fault;
        logic [VEC_W-1:0] vec;
        logic [VA_W-1:0]  paddr;
    } rsp_t;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 16,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int IDX_W = $clog2(NUM_SETS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [WAY_W-1:0]               wr_way,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [VA_W-1:0]                wr_hi,
    input  logic [VA_W-1:0]                wr_lo,
    input  logic [IDX_W-1:0]               rd_idx,
    output logic [NUM_WAYS-1:0][VA_W-1:0]  rd_hi,
    output logic [NUM_WAYS-1:0][VA_W-1:0]  rd_lo
);

    typedef struct packed {
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][VA_W-1:0] hi;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][VA_W-1:0] lo;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.hi[wr_idx][wr_way] = wr_hi;
            st_d.lo[wr_idx][wr_way] = wr_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_hi = st_q.hi[rd_idx];
    assign rd_lo = st_q.lo[rd_idx];

endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
    import tlb_pkg::*;
(
    input  logic [VA_W-1:0]  tag_hi,
    input  logic [VA_W-1:0]  tag_lo,
    input  logic [VPN_W-1:0] vpn,
    input  logic [PID_W-1:0] pid,
    output logic             match
);

    logic unused_fields;
    assign unused_fields = ^{tag_hi[PG_BITS-1:PID_W], tag_lo[VA_W-1:LO_GLB+1],
                             tag_lo[LO_GLB-1:0]};

    logic tag_eq;
    logic owner_ok;

    always_comb begin
        tag_eq   = (tag_hi[VA_W-1:PG_BITS] == vpn);
        owner_ok = tag_lo[LO_GLB] || (tag_hi[PID_W-1:0] == pid);
        match    = tag_eq && owner_ok;
    end

endmodule

// File: rtl/tlb_prot_check.sv
module tlb_prot_check
    import tlb_pkg::*;
(
    input  logic [VA_W-1:0]  tag_lo,
    input  logic [1:0]       kind,
    input  logic             user,
    input  logic [VA_W-1:0]  cfg,
    output logic             fault,
    output logic [VEC_W-1:0] vec
);

    logic unused_cfg;
    assign unused_cfg = ^{cfg[VA_W-1:CFG_WR+1], cfg[CFG_VLD-1:0],
                          tag_lo[VA_W-1:LO_GLB]};

    logic krn_bad, wr_bad, ex_bad, vld_bad;

    always_comb begin
        krn_bad = cfg[CFG_KRN] && tag_lo[LO_KRN] && user;
        wr_bad  = cfg[CFG_WR]  && (kind == ACC_WRITE) && !tag_lo[LO_WR];
        ex_bad  = cfg[CFG_EX]  && (kind == ACC_EXEC)  && !tag_lo[LO_EX];
        vld_bad = cfg[CFG_VLD] && !tag_lo[LO_VLD];

        fault = 1'b1;
        if (krn_bad) begin
            vec = VEC_KERN;
        end else if (wr_bad) begin
            vec = VEC_WRITE;
        end else if (ex_bad) begin
            vec = VEC_EXEC;
        end else if (vld_bad) begin
            vec = VEC_INVAL;
        end else begin
            fault = 1'b0;
            vec   = VEC_MISS;
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 16,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int IDX_W = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic             req_user,
    input  logic [7:0]       req_pid,
    input  logic [31:0]      cfg,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_hi,
    input  logic [31:0]      wr_lo,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [2:0]       rsp_vec,
    output logic [31:0]      rsp_paddr
);

    logic [VPN_W-1:0] vpn;
    logic [IDX_W-1:0] set_idx;
    assign vpn     = req_vaddr[VA_W-1:PG_BITS];
    assign set_idx = vpn[IDX_W-1:0];

    logic [NUM_BANK-1:0][NUM_WAYS-1:0][VA_W-1:0] bank_hi, bank_lo;

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr_en && (wr_bank == b[0]);
        tlb_entry_store #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bank_wr),
            .wr_way (wr_way),
            .wr_idx (wr_idx),
            .wr_hi  (wr_hi),
            .wr_lo  (wr_lo),
            .rd_idx (set_idx),
            .rd_hi  (bank_hi[b]),
            .rd_lo  (bank_lo[b])
        );
    end

    logic [NUM_WAYS-1:0][VA_W-1:0] way_hi, way_lo;
    assign way_hi = (req_kind == ACC_EXEC) ? bank_hi[BANK_INSN] : bank_hi[BANK_DATA];
    assign way_lo = (req_kind == ACC_EXEC) ? bank_lo[BANK_INSN] : bank_lo[BANK_DATA];

    logic [NUM_WAYS-1:0] way_hit;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        tlb_way_match u_match (
            .tag_hi (way_hi[w]),
            .tag_lo (way_lo[w]),
            .vpn    (vpn),
            .pid    (req_pid),
            .match  (way_hit[w])
        );
    end

    // lowest numbered matching way wins
    logic [WAY_W-1:0] hit_way;
    logic             any_hit;
    always_comb begin
        hit_way = '0;
        any_hit = 1'b0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                hit_way = WAY_W'(w);
                any_hit = 1'b1;
            end
        end
    end

    logic [VA_W-1:0]  sel_lo;
    logic             chk_fault;
    logic [VEC_W-1:0] chk_vec;
    assign sel_lo = way_lo[hit_way];

    tlb_prot_check u_prot (
        .tag_lo (sel_lo),
        .kind   (req_kind),
        .user   (req_user),
        .cfg    (cfg),
        .fault  (chk_fault),
        .vec    (chk_vec)
    );

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (!any_hit) begin
                rsp_d.miss = 1'b1;
                rsp_d.vec  = VEC_MISS;
            end else begin
                rsp_d.paddr = {sel_lo[VA_W-1:PG_BITS], req_vaddr[PG_BITS-1:0]};
                rsp_d.fault = chk_fault;
                rsp_d.hit   = !chk_fault;
                rsp_d.vec   = chk_vec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_fault = rsp_q.fault;
    assign rsp_vec   = rsp_q.vec;
    assign rsp_paddr = rsp_q.paddr;

    // R12: one outcome per response
    p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));

    // R12: quiet when no response
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

    // R12: request answered on the next cycle
    p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3: miss carries code 0 and address 0
    p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_vec == VEC_MISS) && (rsp_paddr == '0));

    // R1: page offset passes through on a match
    p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_miss) |->
            (rsp_paddr[PG_BITS-1:0] == $past(req_vaddr[PG_BITS-1:0])));

    // R6: write protection code only after a write request
    p_write_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault && rsp_vec == VEC_WRITE) |-> ($past(req_kind) == ACC_WRITE));

    // R8: invalid code only when the valid check was enabled
    p_inval_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault && rsp_vec == VEC_INVAL) |-> $past(cfg[CFG_VLD]));

endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        req_user;
    logic [7:0]  req_pid;
    logic [31:0] cfg;
    logic        wr_en;
    logic        wr_bank;
    logic [1:0]  wr_way;
    logic [3:0]  wr_idx;
    logic [31:0] wr_hi;
    logic [31:0] wr_lo;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [2:0]  rsp_vec;
    logic [31:0] rsp_paddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .req_pid(req_pid), .cfg(cfg),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_way(wr_way), .wr_idx(wr_idx),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_vec(rsp_vec),
        .rsp_paddr(rsp_paddr)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // outcome codes: 0 hit, 1 miss, 2 fault
    typedef struct packed {
        logic [31:0] vaddr;
        logic [1:0]  kind;
        logic        user;
        logic [7:0]  pid;
        logic [31:0] cfg;
        logic [1:0]  outc;
        logic [2:0]  vec;
        logic [31:0] paddr;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TABLE [NV] = '{
        '{32'h0000BABC, 2'd0, 1'b0, 8'h22, 32'h000F0000, 2'd0, 3'd0, 32'h00247ABC, 4'd11}, // R11 way0 over way3
        '{32'h0000BABC, 2'd0, 1'b0, 8'h33, 32'h000F0000, 2'd1, 3'd0, 32'h00000000, 4'd2},  // R2 pid mismatch
        '{32'h0002A010, 2'd0, 1'b0, 8'h99, 32'h000F0000, 2'd0, 3'd0, 32'h00156010, 4'd2},  // R2 global
        '{32'h0002A010, 2'd0, 1'b1, 8'h99, 32'h000F0000, 2'd2, 3'd2, 32'h00156010, 4'd5},  // R5 kernel
        '{32'h0002A010, 2'd1, 1'b1, 8'h99, 32'h000F0000, 2'd2, 3'd2, 32'h00156010, 4'd9},  // R9 kernel over write
        '{32'h0002A010, 2'd1, 1'b1, 8'h99, 32'h000B0000, 2'd2, 3'd3, 32'h00156010, 4'd6},  // R6 write
        '{32'h0002A010, 2'd1, 1'b1, 8'h99, 32'h00000000, 2'd0, 3'd0, 32'h00156010, 4'd10}, // R10 all off
        '{32'h00012000, 2'd1, 1'b0, 8'h22, 32'h000F0000, 2'd2, 3'd1, 32'h00088000, 4'd8},  // R8 invalid
        '{32'h00012000, 2'd1, 1'b0, 8'h22, 32'h000E0000, 2'd0, 3'd0, 32'h00088000, 4'd10}, // R10 valid off
        '{32'h00006004, 2'd2, 1'b0, 8'h22, 32'h000F0000, 2'd0, 3'd0, 32'h00400004, 4'd4},  // R4 insn bank
        '{32'h00006004, 2'd0, 1'b0, 8'h22, 32'h000F0000, 2'd1, 3'd0, 32'h00000000, 4'd4},  // R4 data bank empty
        '{32'h0000E000, 2'd2, 1'b0, 8'h22, 32'h000F0000, 2'd2, 3'd4, 32'h00600000, 4'd7},  // R7 exec
        '{32'h0002E000, 2'd2, 1'b0, 8'h22, 32'h000F0000, 2'd2, 3'd4, 32'h00002000, 4'd9},  // R9 exec over valid
        '{32'h0002E000, 2'd2, 1'b0, 8'h22, 32'h000D0000, 2'd2, 3'd1, 32'h00002000, 4'd10}, // R10 exec off
        '{32'h00000123, 2'd0, 1'b0, 8'h00, 32'h000F0000, 2'd2, 3'd1, 32'h00000123, 4'd13}, // R13 zeroed entry
        '{32'h00000123, 2'd0, 1'b0, 8'h22, 32'h000F0000, 2'd1, 3'd0, 32'h00000000, 4'd13}  // R13 zeroed entry
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [1:0] outcome();
        if (rsp_hit && !rsp_miss && !rsp_fault) return 2'd0;
        if (!rsp_hit && rsp_miss && !rsp_fault) return 2'd1;
        if (!rsp_hit && !rsp_miss && rsp_fault) return 2'd2;
        return 2'd3;
    endfunction

    task automatic load(input logic bank, input logic [1:0] way, input logic [3:0] idx,
                        input logic [31:0] hi, input logic [31:0] lo);
        wr_en = 1'b1; wr_bank = bank; wr_way = way; wr_idx = idx; wr_hi = hi; wr_lo = lo;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [1:0] k, input logic u,
                          input logic [7:0] p, input logic [31:0] c);
        req_valid = 1'b1; req_vaddr = va; req_kind = k; req_user = u; req_pid = p; cfg = c;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_user = 1'b0;
        req_pid = '0; cfg = '0; wr_en = 1'b0; wr_bank = 1'b0; wr_way = '0; wr_idx = '0;
        wr_hi = '0; wr_lo = '0;
        repeat (3) @(negedge clk);
        // R13 reset state of outputs
        check("R13", {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 32'd0);
        check("R13", rsp_paddr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        load(1'b1, 2'd0, 4'd5, 32'h0000A022, 32'h0024600A);
        load(1'b1, 2'd3, 4'd5, 32'h0000A022, 32'h007FE00A);
        load(1'b1, 2'd2, 4'd5, 32'h0002A077, 32'h0015601C);
        load(1'b1, 2'd1, 4'd9, 32'h00012022, 32'h00088002);
        load(1'b0, 2'd1, 4'd3, 32'h00006022, 32'h00400009);
        load(1'b0, 2'd3, 4'd7, 32'h0000E022, 32'h00600008);
        load(1'b0, 2'd0, 4'd7, 32'h0002E022, 32'h00002000);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", TABLE[i].rq);
            lookup(TABLE[i].vaddr, TABLE[i].kind, TABLE[i].user, TABLE[i].pid, TABLE[i].cfg);
            check({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
            check({tag, " outcome"}, {30'd0, outcome()}, {30'd0, TABLE[i].outc});
            check({tag, " vec"}, {29'd0, rsp_vec}, {29'd0, TABLE[i].vec});
            check({tag, " paddr"}, rsp_paddr, TABLE[i].paddr);
        end

        // R12: no request, no response
        @(negedge clk);
        check("R12", {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 32'd0);

        // R14: write and lookup in the same cycle
        wr_en = 1'b1; wr_bank = 1'b1; wr_way = 2'd0; wr_idx = 4'hB;
        wr_hi = 32'h00016022; wr_lo = 32'h0000A008;
        req_valid = 1'b1; req_vaddr = 32'h00016044; req_kind = 2'd0; req_user = 1'b0;
        req_pid = 8'h22; cfg = 32'h000F0000;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R14 same cycle", {30'd0, outcome()}, 32'd1);
        lookup(32'h00016044, 2'd0, 1'b0, 8'h22, 32'h000F0000);
        check("R14 after", {30'd0, outcome()}, 32'd0);
        check("R1 paddr", rsp_paddr, 32'h0000A044);

        // R4: data-bank write is not visible to execute
        lookup(32'h00016044, 2'd2, 1'b0, 8'h22, 32'h000F0000);
        check("R4 exec bank", {30'd0, outcome()}, 32'd1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule